// File: doc/BRIEF.md
# Configuration access address translator

This block turns a configuration-space request into the pieces an outbound fabric port needs: the transaction kind, the value for the single shared translation region's target register, the choice between the local register space and the translated window, and a dword-aligned address. A request carries a bus number, a device number, a function number, a register offset and a read/write flag. Bus 0 is the local register space. Every deeper bus goes through one translation region, and the region target is rewritten for each such access.

Requests addressed to devices that cannot exist are filtered before anything is issued. On bus 0 only devices 0 and 1 exist, and on bus 1 only device 0 exists. A filtered read completes with all-ones data. A filtered write is flagged as an error. In both cases the pass flag is low and the region target is left alone.

Requests enter on a valid/ready stream. Responses leave on a second valid/ready stream through one register stage. A request is taken when `req_valid` and `req_ready` are both high. `req_ready` is high whenever the output stage is empty or its response is being taken in the same cycle. While `rsp_valid` is high and `rsp_ready` is low, every response field holds its value. The fabric transfer itself and any fault handling belong to the consumer of the response.

Top module: `cfgx_xlate`

## Requirements
- R1: `rsp_type` is 3'd4 (type 0) for buses 0 and 1, and 3'd5 (type 1) for bus 2 and above, whether or not the request is valid.
- R2: For bus 0, `rsp_local` is 1 and `rsp_addr` equals LOCAL_BASE plus the aligned offset. A valid bus-0 request leaves the region target unchanged, so `rsp_target` repeats the previous target (0 after reset).
- R3: For a valid request on bus 1 or above, `rsp_local` is 0, `rsp_addr` equals REMOTE_BASE plus the aligned offset, and `rsp_target` is {bus[7:0] in 31:24, device[4:0] in 23:19, function[2:0] in 18:16, zeros in 15:0}. Later responses keep this target until the next valid remote request.
- R4: The aligned offset is the request offset with bits 1:0 cleared, so `rsp_addr[1:0]` is always 0.
- R5: A request is invalid when it is on bus 0 with device above 1, or on bus 1 with device other than 0. Every other request is valid and gives `rsp_pass`=1. An invalid request gives `rsp_pass`=0.
- R6: An invalid read gives `rsp_rdata`=32'hFFFF_FFFF, `rsp_err`=0, and no change of the region target. Every other response has `rsp_rdata`=0.
- R7: An invalid write gives `rsp_err`=1 and `rsp_pass`=0, and does not change the region target. `rsp_err` is 0 on all other responses.
- R8: After reset `rsp_valid` is 0 and `req_ready` is 1. An accepted request produces `rsp_valid`=1 at the next clock edge.
- R9: `req_ready` equals (not `rsp_valid`) or `rsp_ready`. While `rsp_valid`=1 and `rsp_ready`=0, all response fields are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_bus | input | 8 | Bus number |
| req_dev | input | 5 | Device number |
| req_func | input | 3 | Function number |
| req_ofs | input | 12 | Register byte offset |
| req_write | input | 1 | 1 = write, 0 = read |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_type | output | 3 | Transaction kind, 4 = type 0, 5 = type 1 |
| rsp_target | output | 32 | Translation region target value |
| rsp_local | output | 1 | 1 = local register space, 0 = translated window |
| rsp_addr | output | 32 | Dword-aligned output address |
| rsp_pass | output | 1 | 1 = issue the access, 0 = filtered |
| rsp_err | output | 1 | Filtered write |
| rsp_rdata | output | 32 | Completion data for a filtered read |

## Verification
Every response field is due at the first rising edge after the request is accepted. It then stays until the edge at which `rsp_ready` is seen high, and `req_ready` follows the output state within the same cycle. The bench's behavioural model takes the inputs of each completed cycle at the falling edge, updates its expected output stage and region target, and compares all fields there. The bench then drives the next inputs, and checks `req_ready` one step later. Stalls on `rsp_ready` are mixed into the stimulus, so the hold rule and the edge at which the next request is taken are both checked at those edges.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
  typedef enum logic [2:0] {
    KIND_TYPE0 = 3'd4,
    KIND_TYPE1 = 3'd5
  } cfg_kind_e;
endpackage

// File: rtl/cfgx_validate.sv
module cfgx_validate #(
  parameter int BUS_W        = 8,
  parameter int DEV_W        = 5,
  parameter int BUS0_DEV_MAX = 1,
  parameter int BUS1_DEV_MAX = 0
) (
  input  logic [BUS_W-1:0] bus,
  input  logic [DEV_W-1:0] dev,
  output logic             ok,
  output logic             is_local,
  output logic [2:0]       kind
);
  import cfgx_pkg::*;

  logic on_first;
  logic bad_local;
  logic bad_first;

  always_comb begin
    is_local  = (bus == '0);
    on_first  = (bus == BUS_W'(1));
    bad_local = is_local && (dev > DEV_W'(BUS0_DEV_MAX));
    bad_first = on_first && (dev > DEV_W'(BUS1_DEV_MAX));
    ok        = !(bad_local || bad_first);
    kind      = (bus < BUS_W'(2)) ? KIND_TYPE0 : KIND_TYPE1;
  end
endmodule

// File: rtl/cfgx_map.sv
module cfgx_map #(
  parameter int              BUS_W       = 8,
  parameter int              DEV_W       = 5,
  parameter int              FUN_W       = 3,
  parameter int              OFS_W       = 12,
  parameter int              ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] LOCAL_BASE  = 32'h4000_0000,
  parameter logic [ADDR_W-1:0] REMOTE_BASE = 32'h5000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              ok,
  input  logic              is_local,
  input  logic [BUS_W-1:0]  bus,
  input  logic [DEV_W-1:0]  dev,
  input  logic [FUN_W-1:0]  func,
  input  logic [OFS_W-1:0]  ofs,
  output logic [ADDR_W-1:0] tgt_next,
  output logic [ADDR_W-1:0] addr
);
  localparam int ID_W  = BUS_W + DEV_W + FUN_W;
  localparam int PAD_W = ADDR_W - ID_W;
  localparam logic [ADDR_W-1:0] WIN_MASK = ADDR_W'((64'd1 << OFS_W) - 64'd1);
  localparam bit BASES_ALIGNED =
    ((LOCAL_BASE & WIN_MASK) == '0) && ((REMOTE_BASE & WIN_MASK) == '0);

  logic [ADDR_W-1:0] tgt_q;
  logic [ADDR_W-1:0] id_word;
  logic [OFS_W-1:0]  ofs_al;
  logic [ADDR_W-1:0] base_sel;
  logic              load;

  always_comb begin
    id_word  = {bus, dev, func, {PAD_W{1'b0}}};
    load     = ok && !is_local;
    tgt_next = load ? id_word : tgt_q;
    ofs_al   = ofs & ~OFS_W'(3);
    base_sel = is_local ? LOCAL_BASE : REMOTE_BASE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tgt_q <= '0;
    else if (fire && load) tgt_q <= id_word;
  end

  generate
    if (BASES_ALIGNED) begin : g_or_join
      always_comb addr = base_sel | ADDR_W'(ofs_al);
    end else begin : g_add_join
      always_comb addr = base_sel + ADDR_W'(ofs_al);
    end
  endgenerate

  // R2: a local access leaves the region target alone
  p_local_keeps_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && is_local) |=> $stable(tgt_q));
  // R6 / R7: a filtered request leaves the region target alone
  p_drop_keeps_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !ok) |=> $stable(tgt_q));
endmodule

// File: rtl/cfgx_outstage.sv
module cfgx_outstage #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [PW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [PW-1:0] out_data
);
  logic          full_q;
  logic [PW-1:0] data_q;
  logic          take;

  always_comb begin
    in_ready  = !full_q || out_ready;
    take      = in_valid && in_ready;
    out_valid = full_q;
    out_data  = data_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (take) begin
      full_q <= 1'b1;
      data_q <= in_data;
    end else if (out_ready) begin
      full_q <= 1'b0;
    end
  end

  // R9: a stalled response holds every field
  p_hold_stalled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  // R8: an accepted request is presented at the next edge
  p_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
endmodule

// File: rtl/cfgx_xlate.sv
module cfgx_xlate #(
  parameter int              BUS_W       = 8,
  parameter int              DEV_W       = 5,
  parameter int              FUN_W       = 3,
  parameter int              OFS_W       = 12,
  parameter int              ADDR_W      = 32,
  parameter int              DATA_W      = 32,
  parameter logic [ADDR_W-1:0] LOCAL_BASE  = 32'h4000_0000,
  parameter logic [ADDR_W-1:0] REMOTE_BASE = 32'h5000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BUS_W-1:0]  req_bus,
  input  logic [DEV_W-1:0]  req_dev,
  input  logic [FUN_W-1:0]  req_func,
  input  logic [OFS_W-1:0]  req_ofs,
  input  logic              req_write,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [2:0]        rsp_type,
  output logic [ADDR_W-1:0] rsp_target,
  output logic              rsp_local,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              rsp_pass,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata
);
  localparam int PW = 3 + ADDR_W + 1 + ADDR_W + 1 + 1 + DATA_W;

  logic              ok;
  logic              is_local;
  logic [2:0]        kind;
  logic              fire;
  logic [ADDR_W-1:0] tgt_next;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] rdata;
  logic              err;
  logic [PW-1:0]     pay_in;
  logic [PW-1:0]     pay_out;

  cfgx_validate #(
    .BUS_W(BUS_W), .DEV_W(DEV_W), .BUS0_DEV_MAX(1), .BUS1_DEV_MAX(0)
  ) u_validate (
    .bus(req_bus), .dev(req_dev), .ok(ok), .is_local(is_local), .kind(kind)
  );

  cfgx_map #(
    .BUS_W(BUS_W), .DEV_W(DEV_W), .FUN_W(FUN_W), .OFS_W(OFS_W),
    .ADDR_W(ADDR_W), .LOCAL_BASE(LOCAL_BASE), .REMOTE_BASE(REMOTE_BASE)
  ) u_map (
    .clk(clk), .rst_n(rst_n), .fire(fire), .ok(ok), .is_local(is_local),
    .bus(req_bus), .dev(req_dev), .func(req_func), .ofs(req_ofs),
    .tgt_next(tgt_next), .addr(addr)
  );

  always_comb begin
    fire   = req_valid && req_ready;
    err    = !ok && req_write;
    rdata  = (!ok && !req_write) ? '1 : '0;
    pay_in = {kind, tgt_next, is_local, addr, ok, err, rdata};
  end

  cfgx_outstage #(.PW(PW)) u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid), .in_ready(req_ready), .in_data(pay_in),
    .out_valid(rsp_valid), .out_ready(rsp_ready), .out_data(pay_out)
  );

  assign {rsp_type, rsp_target, rsp_local, rsp_addr, rsp_pass, rsp_err, rsp_rdata} = pay_out;

  // R1: local space is always reached with type 0
  p_local_is_type0_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_local) |-> (rsp_type == 3'd4));
  // R4: output address is dword aligned
  p_addr_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_addr[1:0] == 2'b00));
  // R6: a filtered read returns all ones
  p_drop_read_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_pass && !rsp_err) |-> (rsp_rdata == '1));
  // R7: an error is only raised on a filtered access
  p_err_not_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> !rsp_pass);
endmodule

// File: tb/tb_cfgx_xlate.sv
module tb_cfgx_xlate;
  localparam logic [31:0] LBASE = 32'h4000_0000;
  localparam logic [31:0] RBASE = 32'h5000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_bus = '0;
  logic [4:0]  req_dev = '0;
  logic [2:0]  req_func = '0;
  logic [11:0] req_ofs = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [2:0]  rsp_type;
  logic [31:0] rsp_target;
  logic        rsp_local;
  logic [31:0] rsp_addr;
  logic        rsp_pass;
  logic        rsp_err;
  logic [31:0] rsp_rdata;

  always #2 clk = ~clk;

  cfgx_xlate dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bus(req_bus), .req_dev(req_dev), .req_func(req_func), .req_ofs(req_ofs),
    .req_write(req_write), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_type(rsp_type), .rsp_target(rsp_target), .rsp_local(rsp_local),
    .rsp_addr(rsp_addr), .rsp_pass(rsp_pass), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit cond, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // packed request {write, bus, dev, func, ofs}
  logic [28:0] stim_q[$];

  function automatic logic [28:0] mk(input logic w, input logic [7:0] b, input logic [4:0] d,
                                     input logic [2:0] f, input logic [11:0] o);
    return {w, b, d, f, o};
  endfunction

  // model state
  bit          m_valid = 0;
  logic [2:0]  m_type;
  logic [31:0] m_tgt, m_addr, m_rdata;
  logic        m_local, m_pass, m_err;
  logic [7:0]  m_bus;
  logic [31:0] m_tgt_reg = '0;

  task automatic model_step();
    bit acc;
    bit okv;
    acc = req_valid && (!m_valid || rsp_ready);
    if (acc) begin
      okv = !((req_bus == 0 && req_dev > 1) || (req_bus == 1 && req_dev != 0));
      if (okv && req_bus != 0) m_tgt_reg = {req_bus, req_dev, req_func, 16'h0000};
      m_valid = 1;
      m_bus   = req_bus;
      m_type  = (req_bus < 2) ? 3'd4 : 3'd5;
      m_tgt   = m_tgt_reg;
      m_local = (req_bus == 0);
      m_addr  = ((req_bus == 0) ? LBASE : RBASE) + {20'h0, req_ofs[11:2], 2'b00};
      m_pass  = okv;
      m_err   = !okv && req_write;
      m_rdata = (!okv && !req_write) ? 32'hFFFF_FFFF : 32'h0;
    end else if (m_valid && rsp_ready) begin
      m_valid = 0;
    end
  endtask

  task automatic compare();
    check(rsp_valid == m_valid, "R8 rsp_valid", {31'h0, rsp_valid}, {31'h0, m_valid});
    if (m_valid && rsp_valid) begin
      check(rsp_type == m_type, "R1 rsp_type", {29'h0, rsp_type}, {29'h0, m_type});
      check(rsp_local == m_local, "R2 rsp_local", {31'h0, rsp_local}, {31'h0, m_local});
      check(rsp_addr == m_addr, (m_bus == 0) ? "R2 rsp_addr" : "R3 rsp_addr", rsp_addr, m_addr);
      check(rsp_addr[1:0] == 2'b00, "R4 rsp_addr low bits", rsp_addr, m_addr);
      check(rsp_target == m_tgt, "R3 rsp_target", rsp_target, m_tgt);
      check(rsp_pass == m_pass, "R5 rsp_pass", {31'h0, rsp_pass}, {31'h0, m_pass});
      check(rsp_err == m_err, "R7 rsp_err", {31'h0, rsp_err}, {31'h0, m_err});
      check(rsp_rdata == m_rdata, "R6 rsp_rdata", rsp_rdata, m_rdata);
    end
  endtask

  initial begin
    // directed corners
    stim_q.push_back(mk(0, 8'd0, 5'd0, 3'd0, 12'h007));   // R2 R4
    stim_q.push_back(mk(1, 8'd0, 5'd1, 3'd2, 12'h0FE));   // R2 last valid dev
    stim_q.push_back(mk(0, 8'd0, 5'd2, 3'd0, 12'h010));   // R5 R6 invalid read
    stim_q.push_back(mk(1, 8'd0, 5'd31, 3'd0, 12'h010));  // R7 invalid write
    stim_q.push_back(mk(0, 8'd1, 5'd0, 3'd3, 12'h013));   // R3 bus 1
    stim_q.push_back(mk(0, 8'd1, 5'd1, 3'd0, 12'h020));   // R6 bus1 invalid
    stim_q.push_back(mk(1, 8'd1, 5'd5, 3'd0, 12'h020));   // R7 bus1 invalid write
    stim_q.push_back(mk(0, 8'd2, 5'd7, 3'd5, 12'h101));   // R1 type 1
    stim_q.push_back(mk(1, 8'd255, 5'd31, 3'd7, 12'hFFF)); // R3 extremes
    stim_q.push_back(mk(0, 8'd0, 5'd0, 3'd0, 12'h004));   // R2 target kept
    stim_q.push_back(mk(1, 8'd3, 5'd31, 3'd1, 12'h3FF));  // R1 R3 deep bus write
    for (int i = 0; i < 400; i++) begin
      logic [7:0] b;
      case ($urandom % 4)
        0: b = 8'd0;
        1: b = 8'd1;
        2: b = 8'd2;
        default: b = 8'($urandom);
      endcase
      stim_q.push_back(mk(1'($urandom), b, 5'($urandom % ((b < 2) ? 4 : 32)),
                          3'($urandom), 12'($urandom)));
    end

    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b0, "R8 reset rsp_valid", {31'h0, rsp_valid}, 32'h0);
    check(req_ready == 1'b1, "R8 reset req_ready", {31'h0, req_ready}, 32'h1);
    rst_n = 1'b1;

    while (stim_q.size() > 0 || req_valid || m_valid) begin
      bit acc;
      @(negedge clk);
      acc = req_valid && (!m_valid || rsp_ready);
      model_step();
      compare();
      if (acc || !req_valid) begin
        if (stim_q.size() > 0) begin
          logic [28:0] s;
          s = stim_q.pop_front();
          {req_write, req_bus, req_dev, req_func, req_ofs} = s;
          req_valid = 1'b1;
        end else begin
          req_valid = 1'b0;
        end
      end
      rsp_ready = ($urandom % 4) != 0;
      #1;
      check(req_ready == (!m_valid || rsp_ready), "R9 req_ready",
            {31'h0, req_ready}, {31'h0, (!m_valid || rsp_ready)});
    end
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL R8 watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule